// File: doc/BRIEF.md
# DMA Write Channel Handshake Controller

This block runs the write side of an external DMA handshake. An outside DMA engine uses it to move bytes from system memory into one of eight per-channel transmit buffers. Software programs an 8-bit control register with four fields: a channel abort trigger, an enable, a strobe-mode select and a 3-bit destination channel. It also supplies the message length through a separate input. Each buffer reports how much space it has free.

When the block is enabled and the chosen buffer has room for a whole message, the block drives an active-low request. The DMA engine answers with an active-low acknowledge. Each qualifying falling strobe on the bus then delivers one byte to the buffer that was chosen when the request went out.

The strobe mode decides which pin carries the strobe. In one mode the write line is the strobe. In the other mode the read line is the strobe and the write line gives the direction.

After the last byte of a message, the request goes high again. The block then waits for the acknowledge to clear and checks buffer space before it makes a new request. Writing a 1 into the abort field when it held 0 cancels any transfer in progress.

Top module: `dma_wr_ctrl`

## Requirements
- R1: After the synchronous reset, `cfg_rdata` reads 0x00, `dma_req_n` is 1, `xfer_count` is 0 and no bit of `buf_wr` is set.
- R2: The control register keeps bit 7 (abort trigger), bit 6 (enable), bit 5 (strobe mode) and bits 2:0 (channel) as written. Bits 4:3 always read 0.
- R3: While bit 6 is 0, `dma_req_n` stays 1.
- R4: When enabled, a request is raised only if the free count of the selected channel is at least the message length. A `msg_len` of 0 counts as 1. Otherwise `dma_req_n` stays 1.
- R5: With bit 5 = 1, each falling edge of `bus_wr_n` accepts one byte, provided acknowledge is low. Strobes on `bus_rd_n` are ignored.
- R6: With bit 5 = 0, each falling edge of `bus_rd_n` accepts one byte, provided `bus_wr_n` is low (write direction) and acknowledge is low. A falling edge of `bus_rd_n` while `bus_wr_n` is high is ignored.
- R7: Strobes are ignored while `dma_ack_n` is high.
- R8: Each accepted byte appears on `buf_wdata`, together with a one-cycle, one-hot `buf_wr` pulse at the channel latched when the request was raised. This happens within four clocks of the strobe edge. A channel-select change made during a message only applies to the next message.
- R9: After `msg_len` bytes, `dma_req_n` returns to 1. It stays 1 until acknowledge is high and the buffer again has room, and then it is raised again.
- R10: A register write that sets bit 7 while the stored bit 7 is 0 aborts the transfer: on the next clock `dma_req_n` is 1 and `xfer_count` is 0. A write that keeps bit 7 at 1, or that writes it as 0, does not abort.
- R11: `xfer_count` counts the bytes accepted in the current message. It restarts at 0 when a request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register read value |
| msg_len | input | CNT_W | Bytes per message |
| buf_free | input | 8*CNT_W | Free space of each channel buffer, channel n at bits [n*CNT_W +: CNT_W] |
| dma_req_n | output | 1 | Active-low DMA request |
| dma_ack_n | input | 1 | Active-low DMA acknowledge |
| bus_wr_n | input | 1 | Bus write line (strobe or direction) |
| bus_rd_n | input | 1 | Bus read line (strobe in direction mode) |
| bus_data | input | DW | Bus data byte |
| buf_wr | output | 8 | One-hot buffer write pulse |
| buf_wdata | output | DW | Byte delivered to the buffer |
| xfer_count | output | CNT_W | Bytes accepted in the current message |

## Verification
The bench tests several corner cases, each of which catches a specific design error:

- A buffer with exactly enough room, and one with one byte too little. A wrong comparison would either stall or overfill.
- A length of zero. Mishandling it would stall the request or raise it with no room at all.
- Strobes on the unused pin in each mode, and read-line strobes made while the write line signals "read". A decoder that ignores the mode or the direction would capture extra bytes.
- Strobes sent before the acknowledge. Ungated capture would show up as stray buffer writes.
- A channel change in the middle of a message. A design that did not latch the channel would split the message across two buffers.
- Abort writes that keep or clear bit 7. A level-sensitive abort would drop a live transfer in these cases, while a missing abort would leave the request stuck low.

// File: rtl/dma_wr_pkg.sv
package dma_wr_pkg;
    localparam int NCH  = 8;
    localparam int CH_W = 3;

    typedef struct packed {
        logic            abort_bit;
        logic            en;
        logic            strobe_mode;
        logic [1:0]      rsv;
        logic [CH_W-1:0] ch;
    } cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DRAIN} st_t;

    function automatic cfg_t cfg_clean(logic [7:0] w);
        cfg_t c;
        c     = cfg_t'(w);
        c.rsv = 2'b00;
        return c;
    endfunction

    function automatic logic is_fall(logic prev, logic cur);
        return prev & ~cur;
    endfunction
endpackage

// File: rtl/dma_wr_cfg.sv
module dma_wr_cfg
    import dma_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output cfg_t       cfg,
    output logic       abort
);
    // Abort only on a 0-to-1 change of the stored trigger bit
    assign abort = we & wdata[7] & ~cfg.abort_bit;

    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= cfg_clean(wdata);
    end
endmodule

// File: rtl/dma_wr_strobe.sv
module dma_wr_strobe
    import dma_wr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe_mode,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          ack_n,
    input  logic [DW-1:0] data,
    output logic          ev,
    output logic [DW-1:0] ev_data,
    output logic          ack_lo
);
    // [0] first sync stage, [1] synced value, [2] previous synced value
    logic [2:0]    w_s, r_s;
    logic [1:0]    a_s;
    logic [DW-1:0] d1, d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_s <= '1;
            r_s <= '1;
            a_s <= '1;
            d1  <= '0;
            d2  <= '0;
        end else begin
            w_s <= {w_s[1:0], wr_n};
            r_s <= {r_s[1:0], rd_n};
            a_s <= {a_s[0], ack_n};
            d1  <= data;
            d2  <= d1;
        end
    end

    assign ev      = strobe_mode ? is_fall(w_s[2], w_s[1])
                                 : (is_fall(r_s[2], r_s[1]) & ~w_s[1]);
    assign ev_data = d2;
    assign ack_lo  = ~a_s[1];
endmodule

// File: rtl/dma_wr_fsm.sv
module dma_wr_fsm
    import dma_wr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             en,
    input  logic             room,
    input  logic [CH_W-1:0]  sel,
    input  logic [CNT_W-1:0] len_eff,
    input  logic             ev,
    input  logic [DW-1:0]    ev_data,
    input  logic             ack_lo,
    output logic             req_n,
    output logic [NCH-1:0]   buf_wr,
    output logic [DW-1:0]    buf_wdata,
    output logic [CNT_W-1:0] cnt
);
    st_t              st;
    logic [CH_W-1:0]  act_ch;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt + 1'b1;
    assign req_n   = (st != ST_REQ);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            act_ch    <= '0;
            len_q     <= '0;
            buf_wr    <= '0;
            buf_wdata <= '0;
        end else begin
            buf_wr <= '0;
            unique case (st)
                ST_IDLE: if (en && room) begin
                    st     <= ST_REQ;
                    act_ch <= sel;
                    len_q  <= len_eff;
                    cnt    <= '0;
                end
                ST_REQ: if (ev && ack_lo) begin
                    buf_wr[act_ch] <= 1'b1;
                    buf_wdata      <= ev_data;
                    cnt            <= cnt_nxt;
                    if (cnt_nxt == len_q) st <= ST_DRAIN;
                end
                ST_DRAIN: if (!ack_lo) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_wr_ctrl.sv
module dma_wr_ctrl
    import dma_wr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic [CNT_W-1:0]   msg_len,
    input  logic [NCH*CNT_W-1:0] buf_free,
    output logic               dma_req_n,
    input  logic               dma_ack_n,
    input  logic               bus_wr_n,
    input  logic               bus_rd_n,
    input  logic [DW-1:0]      bus_data,
    output logic [NCH-1:0]     buf_wr,
    output logic [DW-1:0]      buf_wdata,
    output logic [CNT_W-1:0]   xfer_count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cfg_t             cfg;
    logic             abort;
    logic             ev, ack_lo, room;
    logic [DW-1:0]    ev_data;
    logic [CNT_W-1:0] len_eff;
    logic [CNT_W-1:0] free_a [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_free
        assign free_a[g] = buf_free[g*CNT_W +: CNT_W];
    end

    assign len_eff   = (msg_len == '0) ? ONE : msg_len;
    assign room      = (free_a[cfg.ch] >= len_eff);
    assign cfg_rdata = cfg;

    dma_wr_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .abort (abort)
    );

    dma_wr_strobe #(.DW(DW)) u_strobe (
        .clk         (clk),
        .rst         (rst),
        .strobe_mode (cfg.strobe_mode),
        .wr_n        (bus_wr_n),
        .rd_n        (bus_rd_n),
        .ack_n       (dma_ack_n),
        .data        (bus_data),
        .ev          (ev),
        .ev_data     (ev_data),
        .ack_lo      (ack_lo)
    );

    dma_wr_fsm #(.CNT_W(CNT_W), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .abort     (abort),
        .en        (cfg.en),
        .room      (room),
        .sel       (cfg.ch),
        .len_eff   (len_eff),
        .ev        (ev),
        .ev_data   (ev_data),
        .ack_lo    (ack_lo),
        .req_n     (dma_req_n),
        .buf_wr    (buf_wr),
        .buf_wdata (buf_wdata),
        .cnt       (xfer_count)
    );
endmodule

// File: rtl/dma_wr_chk.sv
module dma_wr_chk
    import dma_wr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [7:0]           cfg_wdata,
    input logic [7:0]           cfg_rdata,
    input logic [CNT_W-1:0]     msg_len,
    input logic [NCH*CNT_W-1:0] buf_free,
    input logic                 dma_req_n,
    input logic [NCH-1:0]       buf_wr,
    input logic [CNT_W-1:0]     xfer_count
);
    logic [CH_W-1:0]  sel_c;
    logic [CNT_W-1:0] free_c, len_c;
    logic             room_c;

    assign sel_c  = cfg_rdata[CH_W-1:0];
    assign free_c = buf_free[sel_c*CNT_W +: CNT_W];
    assign len_c  = (msg_len == '0) ? CNT_W'(1) : msg_len;
    assign room_c = (free_c >= len_c);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[4:3] == 2'b00);

    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[6] && dma_req_n) |=> dma_req_n);

    p_req_needs_room_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(dma_req_n) |-> $past(room_c));

    p_write_in_req_r7: assert property (@(posedge clk) disable iff (rst)
        (buf_wr != '0) |-> !$past(dma_req_n));

    p_onehot_write_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(buf_wr));

    p_abort_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[7] && !cfg_rdata[7]) |=> (dma_req_n && xfer_count == '0));

    p_count_steps_r11: assert property (@(posedge clk) disable iff (rst)
        (xfer_count != $past(xfer_count)) |->
            (xfer_count == '0 || xfer_count == CNT_W'($past(xfer_count) + 1'b1)));
endmodule

bind dma_wr_ctrl dma_wr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .msg_len    (msg_len),
    .buf_free   (buf_free),
    .dma_req_n  (dma_req_n),
    .buf_wr     (buf_wr),
    .xfer_count (xfer_count)
);

// File: tb/dma_wr_ctrl_bench.sv
`timescale 1ns/1ps
module dma_wr_ctrl_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_we = 0;
    logic [7:0]  cfg_wdata = 0;
    logic [7:0]  cfg_rdata;
    logic [7:0]  msg_len = 1;
    logic [63:0] buf_free = 0;
    logic        dma_req_n;
    logic        dma_ack_n = 1;
    logic        bus_wr_n = 1;
    logic        bus_rd_n = 1;
    logic [7:0]  bus_data = 0;
    logic [7:0]  buf_wr;
    logic [7:0]  buf_wdata;
    logic [7:0]  xfer_count;

    int n_chk = 0, n_bad = 0, mon_n = 0, multi_hot = 0;
    bit done = 0;
    logic [2:0] mon_ch [0:63];
    logic [7:0] mon_d  [0:63];
    logic [7:0] sent   [0:7];

    always #4 clk = ~clk;

    dma_wr_ctrl u_dma_wr_ctrl (.*);

    always @(negedge clk) begin
        if (!rst && buf_wr != 0) begin
            if ($countones(buf_wr) != 1) multi_hot++;
            if (mon_n < 64) begin
                for (int i = 0; i < 8; i++) if (buf_wr[i]) mon_ch[mon_n] = 3'(i);
                mon_d[mon_n] = buf_wdata;
            end
            mon_n++;
        end
    end

    function automatic bit exp_room(input logic [7:0] free, input logic [7:0] len);
        return free >= ((len == 0) ? 8'd1 : len);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] v);
        return v & 8'hE7;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send_byte(input bit mode, input logic [7:0] d);
        bus_data = d;
        if (mode) begin
            bus_wr_n = 0; tick(4); bus_wr_n = 1;
            bus_rd_n = 0; tick(4); bus_rd_n = 1; tick(2);   // read strobe: ignored (R5)
        end else begin
            bus_wr_n = 0; bus_rd_n = 0; tick(4); bus_rd_n = 1; tick(4); bus_wr_n = 1;
            bus_rd_n = 0; tick(4); bus_rd_n = 1; tick(2);   // read direction: ignored (R6)
        end
    endtask

    task automatic cleanup;
        dma_ack_n = 1;
        cfg_write(8'h00); cfg_write(8'h80); cfg_write(8'h00);
        tick(3);
    endtask

    task automatic check_mon(input int n, input logic [2:0] ch, input string tag);
        check(mon_n == n, tag, mon_n, n);
        for (int i = 0; i < n && i < 8; i++) begin
            check(mon_ch[i] == ch, "R8 channel", mon_ch[i], ch);
            check(mon_d[i] == sent[i], "R8 data", mon_d[i], sent[i]);
        end
    endtask

    task automatic run_xfer(input logic [2:0] ch, input bit mode, input int len, input bit room);
        logic [7:0] fsel;
        cleanup();
        mon_n = 0;
        for (int i = 0; i < 8; i++) buf_free[i*8 +: 8] = 8'($urandom);
        fsel = room ? 8'(len + ($urandom % (256 - len))) : 8'($urandom % len);
        buf_free[ch*8 +: 8] = fsel;
        msg_len = 8'(len);
        cfg_write({1'b0, 1'b1, mode, 2'b00, ch});
        tick(3);
        check(dma_req_n == !exp_room(fsel, msg_len), "R4 request vs room", dma_req_n, !exp_room(fsel, msg_len));
        if (dma_req_n == 0) begin
            dma_ack_n = 0; tick(3);
            for (int i = 0; i < len; i++) begin
                sent[i] = 8'($urandom);
                send_byte(mode, sent[i]);
            end
            tick(6);
            check_mon(len, ch, mode ? "R5 bytes (write strobe)" : "R6 bytes (read strobe)");
            check(xfer_count == len, "R11 count", xfer_count, len);
            check(dma_req_n == 1, "R9 released after message", dma_req_n, 1);
            buf_free[ch*8 +: 8] = 0;
            dma_ack_n = 1; tick(5);
            check(dma_req_n == 1, "R9 no room after ack", dma_req_n, 1);
            buf_free[ch*8 +: 8] = 8'hFF; tick(3);
            check(dma_req_n == 0, "R9 re-request", dma_req_n, 0);
        end else begin
            tick(5);
            check(dma_req_n == 1, "R4 stays idle", dma_req_n, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        tick(4); rst = 0; tick(1);
        // R1 reset state
        check(cfg_rdata == 0, "R1 cfg", cfg_rdata, 0);
        check(dma_req_n == 1, "R1 req", dma_req_n, 1);
        check(xfer_count == 0, "R1 count", xfer_count, 0);
        check(buf_wr == 0, "R1 buf_wr", buf_wr, 0);

        // R2 readback, reserved bits
        cfg_write(8'hFF); tick(1);
        check(cfg_rdata == exp_rd(8'hFF), "R2 readback", cfg_rdata, exp_rd(8'hFF));
        cfg_write(8'h00); tick(1);
        check(cfg_rdata == 0, "R2 clear", cfg_rdata, 0);

        // R3 disabled never requests
        buf_free = '1; msg_len = 1;
        cfg_write(8'h27); tick(8);
        check(dma_req_n == 1, "R3 disabled", dma_req_n, 1);

        // R4 boundaries: len 0 as 1, exact fit, one short
        cleanup(); buf_free = 0; msg_len = 0;
        cfg_write(8'h40); tick(4);
        check(dma_req_n == 1, "R4 len0 no room", dma_req_n, 1);
        buf_free[7:0] = 1; tick(3);
        check(dma_req_n == 0, "R4 len0 room 1", dma_req_n, 0);
        run_xfer(3'd4, 1'b1, 4, 1'b1);
        cleanup(); buf_free = 0; buf_free[39:32] = 3; msg_len = 4;
        cfg_write(8'h44); tick(4);
        check(dma_req_n == 1, "R4 one short", dma_req_n, 1);

        // R7 strobes before ack ignored
        cleanup(); mon_n = 0; buf_free = '1; msg_len = 2;
        cfg_write(8'h63); tick(3);
        send_byte(1'b1, 8'hAA); tick(4);
        check(mon_n == 0, "R7 no capture without ack", mon_n, 0);
        check(xfer_count == 0, "R7 count", xfer_count, 0);

        // R8 channel change mid-message deferred
        cleanup(); mon_n = 0; buf_free = '1; msg_len = 3;
        cfg_write(8'h62); tick(3);
        dma_ack_n = 0; tick(3);
        sent[0] = 8'h11; send_byte(1'b1, sent[0]);
        cfg_write(8'h65);
        sent[1] = 8'h22; send_byte(1'b1, sent[1]);
        sent[2] = 8'h33; send_byte(1'b1, sent[2]);
        tick(6);
        check_mon(3, 3'd2, "R8 byte count");

        // R10 abort on rising trigger only
        cleanup(); msg_len = 3; buf_free = '1;
        cfg_write(8'hE1); tick(3);
        check(dma_req_n == 0, "R10 request after rising write", dma_req_n, 0);
        dma_ack_n = 0; tick(3);
        send_byte(1'b1, 8'h5A); tick(4);
        check(xfer_count == 1, "R11 one byte", xfer_count, 1);
        cfg_write(8'hE1);
        check(xfer_count == 1 && dma_req_n == 0, "R10 held bit no abort", xfer_count, 1);
        cfg_write(8'h61);
        check(xfer_count == 1 && dma_req_n == 0, "R10 zero write no abort", xfer_count, 1);
        cfg_write(8'hE1);
        check(dma_req_n == 1, "R10 abort req", dma_req_n, 1);
        check(xfer_count == 0, "R10 abort count", xfer_count, 0);

        // Random transfers in both modes
        for (int t = 0; t < 24; t++)
            run_xfer(3'($urandom % 8), 1'($urandom % 2), 1 + int'($urandom % 5), ($urandom % 4) != 0);

        check(multi_hot == 0, "R8 one-hot", multi_hot, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule